// File: doc/BRIEF.md
# Packed Element Narrowing, Interleave and Byte Permute Unit

This unit rearranges the contents of two 64-bit vector operands, called the destination and the source, under a 4-bit opcode. It has three groups of operations. The narrowing group converts each element of both operands to half its width and clamps any value that does not fit. The interleave group takes the elements from the lower or the upper half of both operands and weaves them together. The permute group builds each result byte from any byte of the destination, under a control byte taken from the source.

Every operation completes in one cycle. The operands and opcode are sampled on a rising clock edge, and the result is held in a register until the next edge. A vector execution pipeline uses the unit as one of its functional units. Operands come from the register file and the result goes back to it.

Top module: `simd_rearrange_unit`

## Requirements
- R1: While rst_n is low the result reads zero. After reset, the result shows the operation applied to the opcode and operands sampled at the previous rising edge, and it does not change before the next edge.
- R2: Opcode 0 narrows signed 32-bit elements to 16 bits. Result lanes 0..1 come from destination doublewords 0..1 and lanes 2..3 come from source doublewords 0..1. Values above 32767 become 0x7FFF and values below -32768 become 0x8000.
- R3: Opcode 1 narrows signed 16-bit elements to bytes. Result bytes 0..3 come from destination words 0..3 and bytes 4..7 come from source words 0..3. Values above 127 become 0x7F and values below -128 become 0x80.
- R4: Opcode 2 narrows 16-bit elements, read as signed, to unsigned bytes, with the same lane order as R3. Negative inputs become 0x00 and inputs above 255 become 0xFF.
- R5: Opcodes 3, 4 and 5 interleave the lower half of the operands with element widths of 8, 16 and 32 bits. Result element 2k is destination element k and result element 2k+1 is source element k. With a zero source, opcode 3 zero-extends the four low destination bytes to 16-bit words.
- R6: Opcodes 6, 7 and 8 interleave the upper half with element widths of 8, 16 and 32 bits. Result element 2k is destination element N/2+k and result element 2k+1 is source element N/2+k, where N is the number of elements in a 64-bit operand.
- R7: Opcode 9 permutes bytes. Result byte i is the destination byte whose index is given by bits 2:0 of source byte i. Bits 6:3 of the control byte have no effect, so bytes can be reordered or repeated.
- R8: Under opcode 9, any result byte whose control byte has bit 7 set reads 0x00.
- R9: Opcodes 10 to 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand, or byte controls for the permute |
| res_o | output | 64 | Registered result |

## Verification
The narrowing sweeps pair lane values that sit exactly on, one step inside and one step outside each clamp limit. A design that compares unsigned, or truncates instead of clamping, returns wrapped bytes such as 0x00 for 0x0100 or 0x80 for 0x0080. A design that handles negatives wrongly in the unsigned narrowing produces 0xFF for 0xFF80. The interleave checks catch swapped destination and source positions and a wrong half selection. The zero-source case shows any stray bits that were not zero-extended. Every control byte value from 0 to 255 is applied to all eight permute lanes: an index that uses bit 3 reads the wrong byte, and a bit-7 test that is missing passes the byte through instead of clearing it.

// File: rtl/simd_rearrange_pkg.sv
`timescale 1ns/1ps
package simd_rearrange_pkg;

    localparam int unsigned VEC_W = 64;

    typedef enum logic [3:0] {
        OP_NARROW_S32 = 4'd0,
        OP_NARROW_S16 = 4'd1,
        OP_NARROW_U16 = 4'd2,
        OP_WEAVE_LO8  = 4'd3,
        OP_WEAVE_LO16 = 4'd4,
        OP_WEAVE_LO32 = 4'd5,
        OP_WEAVE_HI8  = 4'd6,
        OP_WEAVE_HI16 = 4'd7,
        OP_WEAVE_HI32 = 4'd8,
        OP_PERMUTE    = 4'd9
    } rearr_op_e;

    localparam int unsigned NUM_NARROW = 3;
    localparam int unsigned NUM_WEAVE  = 3;

endpackage

// File: rtl/narrow_pack.sv
`timescale 1ns/1ps
module narrow_pack #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IN_W   = 32,
    parameter bit          UNS    = 1'b0
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int unsigned OUT_W = IN_W / 2;
    localparam int unsigned N     = DATA_W / IN_W;

    localparam logic signed [IN_W-1:0] S_HI =
        $signed({{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [IN_W-1:0] S_LO =
        $signed({{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});
    localparam logic signed [IN_W-1:0] U_HI =
        $signed({{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}});

    function automatic logic [OUT_W-1:0] clamp(input logic signed [IN_W-1:0] x);
        logic [OUT_W-1:0] r;
        if (UNS) begin
            if (x < 0)         r = '0;
            else if (x > U_HI) r = '1;
            else               r = x[OUT_W-1:0];
        end else begin
            if (x > S_HI)      r = {1'b0, {(OUT_W-1){1'b1}}};
            else if (x < S_LO) r = {1'b1, {(OUT_W-1){1'b0}}};
            else               r = x[OUT_W-1:0];
        end
        return r;
    endfunction

    for (genvar k = 0; k < N; k++) begin : g_lane
        logic signed [IN_W-1:0] a_s;
        logic signed [IN_W-1:0] b_s;
        assign a_s = dst_i[k*IN_W +: IN_W];
        assign b_s = src_i[k*IN_W +: IN_W];
        assign res_o[k*OUT_W +: OUT_W]     = clamp(a_s);
        assign res_o[(k+N)*OUT_W +: OUT_W] = clamp(b_s);
    end

endmodule

// File: rtl/lane_weave.sv
`timescale 1ns/1ps
module lane_weave #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ELEM_W = 8
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              hi_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int unsigned N = DATA_W / ELEM_W;
    localparam int unsigned H = N / 2;

    for (genvar k = 0; k < H; k++) begin : g_pair
        logic [ELEM_W-1:0] d_lo, d_hi, s_lo, s_hi;
        assign d_lo = dst_i[k*ELEM_W +: ELEM_W];
        assign d_hi = dst_i[(k+H)*ELEM_W +: ELEM_W];
        assign s_lo = src_i[k*ELEM_W +: ELEM_W];
        assign s_hi = src_i[(k+H)*ELEM_W +: ELEM_W];
        assign res_o[(2*k)*ELEM_W +: ELEM_W]   = hi_i ? d_hi : d_lo;
        assign res_o[(2*k+1)*ELEM_W +: ELEM_W] = hi_i ? s_hi : s_lo;
    end

endmodule

// File: rtl/byte_permute.sv
`timescale 1ns/1ps
module byte_permute #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] ctl_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int unsigned NB    = DATA_W / 8;
    localparam int unsigned IDX_W = $clog2(NB);

    logic [7:0] dbyte [NB];

    for (genvar j = 0; j < NB; j++) begin : g_split
        assign dbyte[j] = dst_i[j*8 +: 8];
    end

    for (genvar i = 0; i < NB; i++) begin : g_out
        logic [7:0]       ctl;
        logic [IDX_W-1:0] idx;
        assign ctl = ctl_i[i*8 +: 8];
        assign idx = ctl[IDX_W-1:0];
        assign res_o[i*8 +: 8] = ctl[7] ? 8'h00 : dbyte[idx];
    end

endmodule

// File: rtl/simd_rearrange_unit.sv
`timescale 1ns/1ps
module simd_rearrange_unit
    import simd_rearrange_pkg::*;
#(
    parameter int unsigned DATA_W = VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] res_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [DATA_W-1:0] narrow_res [NUM_NARROW];
    logic [DATA_W-1:0] weave_res  [NUM_WEAVE];
    logic [DATA_W-1:0] perm_res;
    logic              weave_hi;

    assign weave_hi = (op_i == OP_WEAVE_HI8) || (op_i == OP_WEAVE_HI16) ||
                      (op_i == OP_WEAVE_HI32);

    for (genvar p = 0; p < NUM_NARROW; p++) begin : g_narrow
        narrow_pack #(
            .DATA_W (DATA_W),
            .IN_W   ((p == 0) ? 32 : 16),
            .UNS    (p == 2)
        ) u_narrow (
            .dst_i (dst_i),
            .src_i (src_i),
            .res_o (narrow_res[p])
        );
    end

    for (genvar w = 0; w < NUM_WEAVE; w++) begin : g_weave
        lane_weave #(
            .DATA_W (DATA_W),
            .ELEM_W (8 << w)
        ) u_weave (
            .dst_i (dst_i),
            .src_i (src_i),
            .hi_i  (weave_hi),
            .res_o (weave_res[w])
        );
    end

    byte_permute #(
        .DATA_W (DATA_W)
    ) u_perm (
        .dst_i (dst_i),
        .ctl_i (src_i),
        .res_o (perm_res)
    );

    always_comb begin
        st_d = st_q;
        case (op_i)
            OP_NARROW_S32: st_d.res = narrow_res[0];
            OP_NARROW_S16: st_d.res = narrow_res[1];
            OP_NARROW_U16: st_d.res = narrow_res[2];
            OP_WEAVE_LO8,
            OP_WEAVE_HI8:  st_d.res = weave_res[0];
            OP_WEAVE_LO16,
            OP_WEAVE_HI16: st_d.res = weave_res[1];
            OP_WEAVE_LO32,
            OP_WEAVE_HI32: st_d.res = weave_res[2];
            OP_PERMUTE:    st_d.res = perm_res;
            default:       st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;

    // Clamp of the lowest signed doubleword lane (R2)
    assert_narrow_s32_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NARROW_S32 && $signed(dst_i[31:0]) > 32'sd32767)
        |=> res_o[15:0] == 16'h7FFF);

    // Clamp of the lowest signed word lane at the low end (R3)
    assert_narrow_s16_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NARROW_S16 && $signed(dst_i[15:0]) < -16'sd128)
        |=> res_o[7:0] == 8'h80);

    // Negative input to the unsigned narrowing gives zero (R4)
    assert_narrow_u16_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NARROW_U16 && dst_i[15])
        |=> res_o[7:0] == 8'h00);

    // Zero source makes the low byte interleave a zero extension (R5)
    assert_weave_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WEAVE_LO8 && src_i == '0)
        |=> res_o[15:0] == {8'h00, $past(dst_i[7:0])});

    // Upper doubleword interleave keeps the upper destination element lowest (R6)
    assert_weave_hi32_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WEAVE_HI32)
        |=> res_o[31:0] == $past(dst_i[63:32]) && res_o[63:32] == $past(src_i[63:32]));

    // Permute selection of lane 0 from destination byte 3 (R7)
    assert_permute_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PERMUTE && src_i[7:0] == 8'h03)
        |=> res_o[7:0] == $past(dst_i[31:24]));

    // Permute lane cleared by bit 7 of its control byte (R8)
    assert_permute_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PERMUTE && src_i[7])
        |=> res_o[7:0] == 8'h00);

    // Unassigned opcodes give zero (R9)
    assert_spare_op_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd9)
        |=> res_o == '0);

endmodule

// File: tb/simd_rearrange_unit_test.sv
`timescale 1ns/1ps
module simd_rearrange_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_r = 4'd0;
    logic [63:0] d_r = '0;
    logic [63:0] s_r = '0;
    logic [63:0] res;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    simd_rearrange_unit uut (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op_r),
        .dst_i (d_r),
        .src_i (s_r),
        .res_o (res)
    );

    function automatic logic [15:0] sat16s(input longint v);
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return 16'(v);
    endfunction

    function automatic logic [7:0] sat8(input longint v, input bit uns);
        if (uns) begin
            if (v < 0)   return 8'h00;
            if (v > 255) return 8'hFF;
        end else begin
            if (v > 127)  return 8'h7F;
            if (v < -128) return 8'h80;
        end
        return 8'(v);
    endfunction

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] d,
                                          input logic [63:0] s);
        logic [63:0] r = '0;
        logic [7:0]  db [8];
        int          ew, n, base;
        for (int j = 0; j < 8; j++) db[j] = d[j*8 +: 8];
        case (op)
            4'd0: for (int k = 0; k < 2; k++) begin
                r[k*16 +: 16]     = sat16s(longint'($signed(d[k*32 +: 32])));
                r[(k+2)*16 +: 16] = sat16s(longint'($signed(s[k*32 +: 32])));
            end
            4'd1, 4'd2: for (int k = 0; k < 4; k++) begin
                r[k*8 +: 8]     = sat8(longint'($signed(d[k*16 +: 16])), op == 4'd2);
                r[(k+4)*8 +: 8] = sat8(longint'($signed(s[k*16 +: 16])), op == 4'd2);
            end
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
                ew   = (op < 4'd6) ? (8 << (op - 4'd3)) : (8 << (op - 4'd6));
                n    = 64 / ew;
                base = (op < 4'd6) ? 0 : n / 2;
                for (int k = 0; k < n / 2; k++)
                    for (int b = 0; b < ew; b++) begin
                        r[(2*k)*ew + b]   = d[(base+k)*ew + b];
                        r[(2*k+1)*ew + b] = s[(base+k)*ew + b];
                    end
            end
            4'd9: for (int i = 0; i < 8; i++)
                r[i*8 +: 8] = s[i*8+7] ? 8'h00 : db[s[i*8 +: 3]];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4, 4'd5: return "R5";
            4'd6, 4'd7, 4'd8: return "R6";
            4'd9: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [63:0] d, input logic [63:0] s,
                         input string tag);
        @(negedge clk);
        op_r = op; d_r = d; s_r = s;
        @(negedge clk);
        chk(tag, res, model(op, d, s));
    endtask

    logic [15:0] w16 [12] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                              16'h7FFF, 16'h8000, 16'hFFFF, 16'hFF80, 16'hFF7F, 16'h017F};
    logic [31:0] w32 [10] = '{32'h0000_0000, 32'h0000_7FFF, 32'h0000_8000, 32'hFFFF_8000,
                              32'hFFFF_7FFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                              32'h0000_1234, 32'hFFFF_EDCC};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1: watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] d, s, exp;
        repeat (3) @(negedge clk);
        chk("R1", res, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", res, 64'h0);

        // R1: result changes only after the next rising edge
        op_r = 4'd9; d_r = 64'h8877_6655_4433_2211; s_r = '0;
        #1;
        chk("R1", res, 64'h0);
        @(negedge clk);
        chk("R1", res, {8{8'h11}});

        // R3, R4: word lanes at and around every clamp limit
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++) begin
                d = {w16[i], w16[j], w16[(i+5)%12], w16[(j+7)%12]};
                s = {w16[(j+1)%12], w16[(i+3)%12], w16[j], w16[i]};
                apply(4'd1, d, s, "R3");
                apply(4'd2, d, s, "R4");
            end

        // R2: doubleword lanes at and around the clamp limits
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                apply(4'd0, {w32[i], w32[j]}, {w32[j], w32[(i+4)%10]}, "R2");

        // R5: zero source widens low bytes
        for (int n = 0; n < 20; n++) begin
            d = {$urandom, $urandom};
            exp = '0;
            for (int k = 0; k < 4; k++) exp[k*16 +: 16] = {8'h00, d[k*8 +: 8]};
            @(negedge clk);
            op_r = 4'd3; d_r = d; s_r = '0;
            @(negedge clk);
            chk("R5", res, exp);
        end

        // R5, R6: fixed interleave patterns
        apply(4'd3, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "R5");
        chk("R5", res, 64'h1303_1202_1101_1000);
        apply(4'd8, 64'hAAAA_AAAA_5555_5555, 64'hBBBB_BBBB_6666_6666, "R6");
        chk("R6", res, 64'hBBBB_BBBB_AAAA_AAAA);
        apply(4'd7, 64'h0003_0002_0001_0000, 64'h0013_0012_0011_0010, "R6");
        chk("R6", res, 64'h0013_0003_0012_0002);

        // R7, R8: every control byte value on every lane
        for (int c = 0; c < 256; c++) begin
            d = {$urandom, $urandom};
            s = {8{8'(c)}};
            apply(4'd9, d, s, (c >= 128) ? "R8" : "R7");
        end

        // all opcodes under random operands
        for (int op = 0; op < 16; op++)
            for (int n = 0; n < 200; n++) begin
                d = {$urandom, $urandom};
                s = {$urandom, $urandom};
                apply(4'(op), d, s, tag_of(4'(op)));
            end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule